// File: doc/BRIEF.md
# Patterned Line Draw Engine

This block rasterises a straight line into a frame buffer that stores one bit per pixel per plane, eight pixels to a byte, with the leftmost pixel in the most significant bit. Software programs two endpoints, a 16-bit line style word and a byte offset through a small byte-wide register port. Writing the low byte of the end Y coordinate launches the line. The engine steps along the major axis one dot per clock. It gathers all dots that land in the same frame-buffer byte into one pixel mask, and hands each finished byte to a downstream raster-operation unit as an address and mask request. The downstream unit acknowledges each request with a one-cycle done pulse.

The engine uses a fixed-point stepper. A per-step increment of ((minor+1)*1024)/major is computed once per line by a serial divider. The minor axis moves whenever the accumulator passes 1024. Dots outside the screen are dropped. The style word rotates on every dot. After the line, `busy` stays high for a time that grows with the number of bytes touched, which models the cost of long lines.

Top module: `lineDrawEngine`

## Requirements
- R1: Byte registers at `regAddr` 0/1 hold the offset (high/low), 2/3 the style word, 4/5 start X, 6/7 start Y, 8/9 end X and 10/11 end Y. Coordinates are 16-bit two's complement. A write to address 11 while idle starts a line. Addresses 12 to 15 have no effect.
- R2: A dot at (x,y) belongs to the byte at ((y*scrWidth)>>3) + (x>>3) + 2*offset. With `tallMode`=1 the address is taken modulo 2^15, and with `tallMode`=0 it is taken modulo 2^14 (bit 14 zero).
- R3: The request mask starts at 0xFF. For each drawn dot whose style word has its MSB set at that step, bit (7 - x mod 8) is cleared. A 0 bit therefore marks a pixel to paint.
- R4: The style word rotates left by one bit on every step along the line, including steps whose dot is clipped.
- R5: When an on-screen dot falls in a different byte from the one being gathered, the gathered byte is issued first. After each issue the mask returns to 0xFF. The last gathered byte is issued after the final dot. Every request is held with a stable address and mask until `ropDone`, and requests arrive in drawing order.
- R6: Dots with x<0, y<0, x>=scrWidth or y>=scrHeight touch no byte and produce no request.
- R7: The major axis is X when |dx|>=|dy|, otherwise Y. There are major+1 dots. After each dot the accumulator adds ((minor+1)*1024)/major. When the sum exceeds 1024, the minor coordinate steps toward its end and 1024 is subtracted. The major coordinate steps on every dot.
- R8: A line whose endpoints are equal draws exactly one dot.
- R9: `busy` rises on the cycle after the start write. If more than 8 bytes were issued, `busy` stays high for bytes*CLK_MHZ/16 cycles after the final done. Otherwise it falls on the cycle after the final done (or after the final dot if nothing was issued).
- R10: Register writes while `busy` is high are ignored, and a write to address 11 while busy does not restart the line.
- R11: After reset, `busy` and `reqValid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register byte select |
| regData | input | 8 | Register write data |
| scrWidth | input | 16 | Screen width in pixels |
| scrHeight | input | 16 | Screen height in lines |
| tallMode | input | 1 | 1: 15-bit address wrap, 0: 14-bit wrap (sampled at line start) |
| ropDone | input | 1 | Raster-op unit finished the current request |
| reqValid | output | 1 | Byte request pending |
| reqAddr | output | 15 | Byte address of the request |
| reqMask | output | 8 | Pixel mask, 0 bits are painted |
| busy | output | 1 | Line in progress or busy tail running |

## Verification
The bench sweeps endpoints over a small 64x16 screen in every octant, starting inside, on and beyond the edges. It compares each request, in order, with a model built from the stepping rule. A wrong minor-step threshold (>= instead of >) or a wrong increment shows up as a dot in the wrong row or column and a mismatched address or mask. Lines that leave the screen check that clipped dots still rotate the style word: a design that freezes the pattern there paints the wrong pixels after re-entry. Directed cases cover the single-dot line, a byte whose dots are all style-disabled (still issued with 0xFF), the address wrap in both modes, and a long vertical line whose busy tail length is measured cycle by cycle. A final case writes registers mid-line: a design that accepts those writes would restart the line or carry a corrupted offset into the following line.

// File: rtl/lineEnginePkg.sv
package lineEnginePkg;
  localparam int COORD_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_DIV, ST_DOT, ST_ISSUE, ST_FINAL, ST_TAIL
  } lineState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic setup;      // latch endpoints, seed divider and stepper
    logic divStep;    // one restoring-divide iteration
    logic applyDot;   // merge current dot, rotate style, advance
    logic flushDone;  // downstream accepted gathered byte
    logic loadTail;   // load busy tail counter
    logic tailTick;   // count tail down
  } lineStrobe_t;
endpackage

// File: rtl/lineControl.sv
module lineControl
  import lineEnginePkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startHit,
  input  logic        divDone,
  input  logic        lastDot,
  input  logic        needFlush,
  input  logic        haveByte,
  input  logic        tailWanted,
  input  logic        tailLast,
  input  logic        ropDone,
  output lineStrobe_t strb,
  output logic        idle,
  output logic        busy,
  output logic        reqValid
);
  lineState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strb      = '0;
    case (state)
      ST_IDLE:  if (startHit) stateNext = ST_SETUP;
      ST_SETUP: begin
        strb.setup = 1'b1;
        stateNext  = ST_DIV;
      end
      ST_DIV: begin
        if (divDone) stateNext = ST_DOT;
        else         strb.divStep = 1'b1;
      end
      ST_DOT: begin
        if (needFlush) stateNext = ST_ISSUE;
        else begin
          strb.applyDot = 1'b1;
          if (lastDot) stateNext = ST_FINAL;
        end
      end
      ST_ISSUE: begin
        if (ropDone) begin
          strb.flushDone = 1'b1;
          stateNext      = ST_DOT;
        end
      end
      ST_FINAL: begin
        if (!haveByte || ropDone) begin
          strb.flushDone = haveByte;
          if (tailWanted) begin
            strb.loadTail = 1'b1;
            stateNext     = ST_TAIL;
          end else begin
            stateNext = ST_IDLE;
          end
        end
      end
      ST_TAIL: begin
        strb.tailTick = 1'b1;
        if (tailLast) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign idle     = (state == ST_IDLE);
  assign busy     = !idle;
  assign reqValid = (state == ST_ISSUE) || (state == ST_FINAL && haveByte);

  // R1
  start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (idle && startHit) |=> busy);

  // R5
  issue_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ISSUE && !ropDone) |=> (state == ST_ISSUE));
endmodule

// File: rtl/lineDatapath.sv
module lineDatapath
  import lineEnginePkg::*;
#(
  parameter int ADDR_W  = 15,
  parameter int CLK_MHZ = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [3:0]        regAddr,
  input  logic [7:0]        regData,
  input  logic [15:0]       scrWidth,
  input  logic [15:0]       scrHeight,
  input  logic              tallMode,
  input  logic              idle,
  input  lineStrobe_t       strb,
  output logic              startHit,
  output logic              divDone,
  output logic              lastDot,
  output logic              needFlush,
  output logic              haveByte,
  output logic              tailWanted,
  output logic              tailLast,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [7:0]        reqMask
);
  localparam int DW    = COORD_W + 1;       // signed delta / magnitude
  localparam int PW    = COORD_W + 2;       // running position
  localparam int NUMW  = DW + 10;           // dividend (minor+1)*1024
  localparam int DCW   = $clog2(NUMW + 1);
  localparam int ACCW  = 12;                // holds up to 1024+2048
  localparam int CNTW  = DW + 1;
  localparam int TAILW = CNTW + 8;

  logic [COORD_W-1:0] offReg, patReg, xsReg, ysReg, xeReg, yeReg, patQ;
  logic signed [DW-1:0] dxS, dyS;
  logic [DW-1:0] adx, ady, majLen, minLen, minPlus, stepsLeft, den, rem;
  logic [DW:0]   remNext;
  logic [NUMW-1:0] quo;
  logic [DCW-1:0]  divCnt;
  logic signed [PW-1:0] cx, cy, xInc, yInc;
  logic xMajQ, xNegQ, yNegQ, tallQ, moveX, moveY;
  logic [ACCW-1:0] acc;
  logic [ACCW:0]   accSum;
  logic carryMinor;
  logic [7:0] maskQ, dotBit;
  logic [ADDR_W-1:0] oldAddr, rowBase, sumAddr, byteAddr;
  logic inScreen, haveQ;
  logic [CNTW-1:0]  byteCnt, totalCnt;
  logic [TAILW-1:0] tailCnt, tailLoad;

  // ---------------- register file ----------------
  assign startHit = regWrEn && idle && (regAddr == 4'd11);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offReg <= '0; patReg <= '0; xsReg <= '0;
      ysReg  <= '0; xeReg  <= '0; yeReg <= '0;
    end else if (regWrEn && idle) begin
      case (regAddr)
        4'd0:  offReg[15:8] <= regData;
        4'd1:  offReg[7:0]  <= regData;
        4'd2:  patReg[15:8] <= regData;
        4'd3:  patReg[7:0]  <= regData;
        4'd4:  xsReg[15:8]  <= regData;
        4'd5:  xsReg[7:0]   <= regData;
        4'd6:  ysReg[15:8]  <= regData;
        4'd7:  ysReg[7:0]   <= regData;
        4'd8:  xeReg[15:8]  <= regData;
        4'd9:  xeReg[7:0]   <= regData;
        4'd10: yeReg[15:8]  <= regData;
        4'd11: yeReg[7:0]   <= regData;
        default: ;
      endcase
    end
  end

  // ---------------- line geometry ----------------
  assign dxS = $signed({xeReg[COORD_W-1], xeReg}) - $signed({xsReg[COORD_W-1], xsReg});
  assign dyS = $signed({yeReg[COORD_W-1], yeReg}) - $signed({ysReg[COORD_W-1], ysReg});
  assign adx = dxS[DW-1] ? DW'(-dxS) : DW'(dxS);
  assign ady = dyS[DW-1] ? DW'(-dyS) : DW'(dyS);
  assign majLen  = (adx >= ady) ? adx : ady;
  assign minLen  = (adx >= ady) ? ady : adx;
  assign minPlus = minLen + DW'(1);

  // ---------------- serial restoring divider ----------------
  assign remNext = {rem, quo[NUMW-1]};
  assign divDone = (divCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      quo <= '0; rem <= '0; den <= '0; divCnt <= '0;
    end else if (strb.setup) begin
      quo    <= {minPlus, 10'b0};
      rem    <= '0;
      den    <= majLen;
      divCnt <= DCW'(NUMW);
    end else if (strb.divStep) begin
      divCnt <= divCnt - DCW'(1);
      if (remNext >= {1'b0, den}) begin
        rem <= DW'(remNext - {1'b0, den});
        quo <= {quo[NUMW-2:0], 1'b1};
      end else begin
        rem <= remNext[DW-1:0];
        quo <= {quo[NUMW-2:0], 1'b0};
      end
    end
  end

  // ---------------- stepper ----------------
  assign accSum     = {1'b0, acc} + {1'b0, quo[ACCW-1:0]};
  assign carryMinor = accSum > (ACCW+1)'(1024);
  assign moveX      = xMajQ || carryMinor;
  assign moveY      = !xMajQ || carryMinor;
  assign xInc       = xNegQ ? '1 : PW'(1);
  assign yInc       = yNegQ ? '1 : PW'(1);
  assign lastDot    = (stepsLeft == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cx <= '0; cy <= '0; acc <= '0; stepsLeft <= '0; patQ <= '0;
      xMajQ <= 1'b0; xNegQ <= 1'b0; yNegQ <= 1'b0; tallQ <= 1'b0;
    end else if (strb.setup) begin
      cx        <= {{2{xsReg[COORD_W-1]}}, xsReg};
      cy        <= {{2{ysReg[COORD_W-1]}}, ysReg};
      acc       <= '0;
      stepsLeft <= majLen;
      patQ      <= patReg;
      xMajQ     <= (adx >= ady);
      xNegQ     <= dxS[DW-1];
      yNegQ     <= dyS[DW-1];
      tallQ     <= tallMode;
    end else if (strb.applyDot) begin
      patQ      <= {patQ[COORD_W-2:0], patQ[COORD_W-1]};
      acc       <= carryMinor ? ACCW'(accSum - (ACCW+1)'(1024)) : accSum[ACCW-1:0];
      stepsLeft <= stepsLeft - DW'(1);
      if (moveX) cx <= cx + xInc;
      if (moveY) cy <= cy + yInc;
    end
  end

  // ---------------- byte addressing and gathering ----------------
  assign inScreen = !cx[PW-1] && !cy[PW-1]
                 && (cx[PW-2:0] < {1'b0, scrWidth})
                 && (cy[PW-2:0] < {1'b0, scrHeight});
  assign rowBase  = ADDR_W'((32'(cy[COORD_W-1:0]) * 32'(scrWidth)) >> 3);
  assign sumAddr  = rowBase + ADDR_W'(cx[COORD_W-1:3]) + ADDR_W'({offReg, 1'b0});
  assign byteAddr = tallQ ? sumAddr : {1'b0, sumAddr[ADDR_W-2:0]};
  assign dotBit   = 8'h80 >> cx[2:0];
  assign needFlush = inScreen && haveQ && (byteAddr != oldAddr);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ <= 8'hFF; haveQ <= 1'b0; oldAddr <= '0; byteCnt <= '0;
    end else if (strb.setup) begin
      maskQ <= 8'hFF; haveQ <= 1'b0; byteCnt <= '0;
    end else if (strb.flushDone) begin
      maskQ   <= 8'hFF;
      haveQ   <= 1'b0;
      byteCnt <= byteCnt + CNTW'(1);
    end else if (strb.applyDot && inScreen) begin
      haveQ   <= 1'b1;
      oldAddr <= byteAddr;
      if (patQ[COORD_W-1]) maskQ <= maskQ & ~dotBit;
    end
  end

  assign haveByte = haveQ;
  assign reqAddr  = oldAddr;
  assign reqMask  = maskQ;

  // ---------------- busy tail ----------------
  assign totalCnt   = byteCnt + CNTW'(haveQ);
  assign tailLoad   = TAILW'((TAILW'(totalCnt) * TAILW'(CLK_MHZ)) >> 4);
  assign tailWanted = (totalCnt > CNTW'(8)) && (tailLoad != '0);
  assign tailLast   = (tailCnt <= TAILW'(1));

  always_ff @(posedge clk) begin
    if (!rstN)              tailCnt <= '0;
    else if (strb.loadTail) tailCnt <= tailLoad;
    else if (strb.tailTick) tailCnt <= tailCnt - TAILW'(1);
  end

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !idle |=> ($stable(yeReg) && $stable(offReg) && $stable(patReg) && $stable(xsReg)));

  // R7
  step_cnt_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.applyDot |=> (stepsLeft == DW'($past(stepsLeft) - DW'(1))));

  // R9
  tail_dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tailTick && !tailLast) |=> (tailCnt == TAILW'($past(tailCnt) - TAILW'(1))));

  // R2
  short_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (haveQ && !tallQ) |-> !oldAddr[ADDR_W-1]);

  // R3
  mask_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.flushDone |=> (maskQ == 8'hFF));
endmodule

// File: rtl/lineDrawEngine.sv
module lineDrawEngine
  import lineEnginePkg::*;
#(
  parameter int ADDR_W  = 15,
  parameter int CLK_MHZ = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [3:0]        regAddr,
  input  logic [7:0]        regData,
  input  logic [15:0]       scrWidth,
  input  logic [15:0]       scrHeight,
  input  logic              tallMode,
  input  logic              ropDone,
  output logic              reqValid,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [7:0]        reqMask,
  output logic              busy
);
  lineStrobe_t strb;
  logic idle, startHit, divDone, lastDot, needFlush, haveByte, tailWanted, tailLast;

  lineControl u_ctrl (
    .clk(clk), .rstN(rstN), .startHit(startHit), .divDone(divDone),
    .lastDot(lastDot), .needFlush(needFlush), .haveByte(haveByte),
    .tailWanted(tailWanted), .tailLast(tailLast), .ropDone(ropDone),
    .strb(strb), .idle(idle), .busy(busy), .reqValid(reqValid)
  );

  lineDatapath #(.ADDR_W(ADDR_W), .CLK_MHZ(CLK_MHZ)) u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regData(regData), .scrWidth(scrWidth), .scrHeight(scrHeight),
    .tallMode(tallMode), .idle(idle), .strb(strb), .startHit(startHit),
    .divDone(divDone), .lastDot(lastDot), .needFlush(needFlush),
    .haveByte(haveByte), .tailWanted(tailWanted), .tailLast(tailLast),
    .reqAddr(reqAddr), .reqMask(reqMask)
  );

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !ropDone) |=> (reqValid && $stable(reqAddr) && $stable(reqMask)));

  // R9
  busy_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> busy);
endmodule

// File: tb/lineDrawEngine_tb.sv
module lineDrawEngine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 64;
  localparam int H = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [3:0] regAddr = '0;
  logic [7:0] regData = '0;
  logic tallMode = 1'b0;
  logic ropDone = 1'b0;
  logic reqValid, busy;
  logic [14:0] reqAddr;
  logic [7:0] reqMask;

  int nChecks = 0;
  int nFails = 0;
  int expAddr [0:511];
  int expMask [0:511];
  int expN = 0;
  int gotIdx = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lineDrawEngine u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regData(regData), .scrWidth(16'(W)), .scrHeight(16'(H)),
    .tallMode(tallMode), .ropDone(ropDone), .reqValid(reqValid),
    .reqAddr(reqAddr), .reqMask(reqMask), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  // reference model: expected request list from the stepping rules
  task automatic buildExp(input int xs, input int ys, input int xe, input int ye,
                          input int pat, input int off, input bit tall);
    int dx, dy, ax, ay, maj, mn, diff, cx, cy, acc, mask, old, p, a;
    bit have, xm, carry;
    dx = xe - xs; dy = ye - ys;
    ax = dx < 0 ? -dx : dx; ay = dy < 0 ? -dy : dy;
    xm = ax >= ay;
    maj = xm ? ax : ay; mn = xm ? ay : ax;
    diff = (maj != 0) ? ((mn + 1) * 1024) / maj : 0;
    cx = xs; cy = ys; acc = 0; mask = 255; have = 0; old = 0; p = pat & 16'hFFFF;
    expN = 0;
    for (int i = 0; i <= maj; i++) begin
      if (cx >= 0 && cy >= 0 && cx < W && cy < H) begin
        a = (((cy * W) >> 3) + (cx >> 3) + 2 * off) & (tall ? 32'h7FFF : 32'h3FFF);
        if (have && a != old) begin
          expAddr[expN] = old; expMask[expN] = mask; expN++;
          mask = 255; have = 0;
        end
        if (!have) begin old = a; have = 1; end
        if ((p & 16'h8000) != 0) mask = mask & ~(8'h80 >> (cx & 7)) & 255;
      end
      p = ((p << 1) | (p >> 15)) & 16'hFFFF;
      acc = acc + diff;
      carry = acc > 1024;
      if (carry) acc = acc - 1024;
      if (xm) begin
        cx = cx + (dx < 0 ? -1 : 1);
        if (carry) cy = cy + (dy < 0 ? -1 : 1);
      end else begin
        cy = cy + (dy < 0 ? -1 : 1);
        if (carry) cx = cx + (dx < 0 ? -1 : 1);
      end
    end
    if (have) begin expAddr[expN] = old; expMask[expN] = mask; expN++; end
  endtask

  task automatic writeReg(input int a, input int d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 4'(a); regData = 8'(d);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  // responder: acknowledges and checks each request (R2, R3, R5)
  initial begin
    forever begin
      @(negedge clk);
      if (ropDone) ropDone = 1'b0;
      else if (reqValid) begin
        if (gotIdx >= expN) begin
          check(1'b0, "R5 extra request", gotIdx, expN);
        end else begin
          check(int'(reqAddr) == expAddr[gotIdx], "R2 address", int'(reqAddr), expAddr[gotIdx]);
          check(int'(reqMask) == expMask[gotIdx], "R3 mask", int'(reqMask), expMask[gotIdx]);
        end
        gotIdx++;
        ropDone = 1'b1;
      end
    end
  end

  task automatic drawLine(input int xs, input int ys, input int xe, input int ye,
                          input int pat, input int off, input bit tall,
                          input bit skipOff, input string req);
    int tail;
    buildExp(xs, ys, xe, ye, pat, off, tall);
    gotIdx = 0;
    tallMode = tall;
    if (!skipOff) begin
      writeReg(0, (off >> 8) & 255); writeReg(1, off & 255);
    end
    writeReg(2, (pat >> 8) & 255); writeReg(3, pat & 255);
    writeReg(4, (xs >> 8) & 255);  writeReg(5, xs & 255);
    writeReg(6, (ys >> 8) & 255);  writeReg(7, ys & 255);
    writeReg(8, (xe >> 8) & 255);  writeReg(9, xe & 255);
    writeReg(10, (ye >> 8) & 255); writeReg(11, ye & 255);
    check(busy == 1'b1, "R9 busy after start", int'(busy), 1);
    tail = 0;
    if (expN > 0) begin
      wait (gotIdx >= expN);
      @(negedge clk);
    end
    while (busy) begin
      tail++;
      @(negedge clk);
    end
    if (expN > 0)
      check(tail == (expN > 8 ? expN : 0), {req, " R9 tail"}, tail, (expN > 8 ? expN : 0));
    check(gotIdx == expN, {req, " R5 count"}, gotIdx, expN);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired gotIdx=%0d expected=%0d", gotIdx, expN);
    finish();
  end

  initial begin
    int xs0 [3] = '{0, 7, 30};
    int ys0 [2] = '{0, 9};
    int xe0 [5] = '{-2, 3, 8, 40, 70};
    int ye0 [4] = '{-1, 5, 15, 20};
    int pats [4] = '{16'hFFFF, 16'hF0F0, 16'h8001, 16'h3C5A};
    int k;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(busy == 1'b0, "R11 busy", int'(busy), 0);
    check(reqValid == 1'b0, "R11 reqValid", int'(reqValid), 0);

    // R1 unmapped addresses do not start a line
    writeReg(12, 0); writeReg(15, 0);
    @(negedge clk);
    check(busy == 1'b0, "R1 unmapped write", int'(busy), 0);

    // R8 single dot
    drawLine(10, 3, 10, 3, 16'hFFFF, 0, 1'b1, 1'b0, "R8 single dot");
    check(expN == 1 && expAddr[0] == 25 && expMask[0] == 8'hDF, "R8 model", expMask[0], 8'hDF);

    // R5 dots within one byte merge
    drawLine(8, 2, 15, 2, 16'hFFFF, 0, 1'b1, 1'b0, "R5 one byte");
    // R3 all dots disabled by style: byte still issued with 0xFF
    drawLine(0, 4, 20, 4, 16'h0000, 0, 1'b1, 1'b0, "R3 blank style");
    drawLine(0, 5, 63, 5, 16'hAAAA, 0, 1'b1, 1'b0, "R3 alternate style");
    // R9 long vertical line, 16 bytes, tail of 16 cycles
    drawLine(5, 0, 5, 15, 16'hFFFF, 0, 1'b1, 1'b0, "R9 vertical");
    // R6 wholly clipped line
    drawLine(-5, -5, -1, -9, 16'hFFFF, 0, 1'b1, 1'b0, "R6 offscreen");
    drawLine(60, 2, 70, 2, 16'hFFFF, 0, 1'b1, 1'b0, "R6 right edge");
    // R4 style keeps rotating through clipped dots
    drawLine(-4, 0, 7, 0, 16'h0F00, 0, 1'b1, 1'b0, "R4 clipped rotation");
    // R2 wrap: offset 0x2001 adds 0x4002
    drawLine(0, 1, 9, 1, 16'hFFFF, 16'h2001, 1'b0, 1'b0, "R2 short wrap");
    drawLine(0, 1, 9, 1, 16'hFFFF, 16'h2001, 1'b1, 1'b0, "R2 tall no wrap");

    // R7 sweep across octants
    k = 0;
    foreach (xs0[a]) foreach (ys0[b]) foreach (xe0[c]) foreach (ye0[d]) begin
      drawLine(xs0[a], ys0[b], xe0[c], ye0[d], pats[k % 4], (k % 3) * 3,
               1'(k % 2), 1'b0, "R7 sweep");
      k++;
    end

    // R10 writes while busy are ignored
    drawLine(0, 0, 0, 0, 16'hFFFF, 5, 1'b1, 1'b0, "R10 set offset");
    fork
      drawLine(2, 0, 2, 15, 16'hFFFF, 5, 1'b1, 1'b1, "R10 long line");
      begin
        wait (busy);
        writeReg(0, 8'h77); writeReg(1, 8'h77); writeReg(11, 8'h03);
      end
    join
    drawLine(3, 1, 30, 6, 16'hFFFF, 5, 1'b1, 1'b1, "R10 offset kept");

    repeat (4) @(negedge clk);
    finish();
  end
endmodule